// File: doc/BRIEF.md
# Ethernet Transmit Header Generator

This block turns an outbound byte stream into complete Ethernet frames ready for a MAC. Each packet enters with a port identifier on its first byte. That identifier selects an entry in a small per-port table. The entry supplies the destination MAC, the ethertype, a destination IP address, a destination UDP port and two switches. One switch enables IPv4/UDP encapsulation. The other enables a short streaming prefix ahead of the payload. The source MAC, source IP and source UDP port come from shared configuration inputs.

The payload is written first, at the offset the header will need. Once the last byte has arrived, the byte count is known. The block then writes the header bytes, with the length fields and the IPv4 checksum filled in, at the start of the same slot. Each frame takes one fixed-size slot of a byte-addressed transmit buffer. When a frame is complete, the block queues a command word holding its address and size, and pulses an interrupt. The consumer pops commands and hands slots back in the order they were issued. When every slot is in use, or the command queue is full, the input is held off.

Top module: `ethtx_hdrgen`

## Requirements
- R1: Frame bytes 0..5 hold the destination MAC from the packet's table entry, bytes 6..11 hold `cfg_src_mac`, and bytes 12..13 hold the entry's ethertype. All fields are written most significant byte first.
- R2: When the entry's IP switch is 1, an IPv4 header occupies bytes 14..33. It carries 0x45, 0x00, the total length, identification 0, flags/fragment 0x4000, TTL 0x40, protocol 0x11, the checksum, `cfg_src_ip` and the entry's destination IP. A UDP header follows at bytes 34..41 with `cfg_src_udp`, the entry's destination port, the UDP length and a checksum of 0x0000.
- R3: IPv4 total length = 28 + prefix bytes + payload bytes, and UDP length = 8 + prefix bytes + payload bytes. The IPv4 checksum is the bitwise inverse of the end-around-carry sum of the ten 16-bit header words, with the checksum word taken as zero.
- R4: When the IP switch is 0, no IP or UDP bytes are emitted: the prefix, or the payload if there is no prefix, starts at byte 14. Payload bytes follow in arrival order.
- R5: When the entry's streaming switch is 1, a 4-byte prefix precedes the payload. Byte 0 has upper nibble 0x1, and its lower nibble counts the streamed frames completed earlier, modulo 16. Byte 1 is the port ID zero-extended. Bytes 2..3 give the payload byte count, big-endian. When the switch is 0, no prefix is emitted.
- R6: No frame check sequence is added. The reported size equals header plus payload bytes exactly, and no buffer byte beyond that size is written.
- R7: Slots are used in rotation from 0, and slot k starts at byte address k*SLOT_BYTES. The command word holds the slot start address in bits [15:0] and the frame size in bits [29:16], with bits [31:30] zero.
- R8: `irq` is high for exactly one cycle per queued command, while `cmd_valid` is high.
- R9: Between packets, `in_ready` is low while all NUM_SLOTS slots are outstanding (queued and not yet released) or the command queue is full. It returns high the cycle after a `slot_release` frees a slot.
- R10: Payload bytes that would put the frame beyond MAX_FRAME bytes are accepted and discarded. Such a frame is reported with size MAX_FRAME, and its length fields count only the kept bytes.
- R11: Commands leave the queue in the order the frames completed. `cmd_pop` while the queue is empty has no effect.
- R12: A table write to one port changes the header of later packets on that port only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_mac | input | 48 | Source MAC for all frames |
| cfg_src_ip | input | 32 | Source IPv4 address |
| cfg_src_udp | input | 16 | Source UDP port |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | PW | Port entry to write |
| tbl_dmac | input | 48 | Destination MAC for the entry |
| tbl_etype | input | 16 | Ethertype for the entry |
| tbl_dip | input | 32 | Destination IPv4 address for the entry |
| tbl_dport | input | 16 | Destination UDP port for the entry |
| tbl_ip_en | input | 1 | IP/UDP encapsulation switch |
| tbl_strm_en | input | 1 | Streaming prefix switch |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted when high with in_valid |
| in_data | input | 8 | Payload byte |
| in_port | input | PW | Port ID, sampled on a packet's first byte |
| in_last | input | 1 | Marks the final payload byte |
| buf_we | output | 1 | Transmit buffer write strobe |
| buf_addr | output | AW | Transmit buffer byte address |
| buf_wdata | output | 8 | Transmit buffer write byte |
| cmd_valid | output | 1 | Command queue not empty |
| cmd_word | output | 32 | Oldest queued command |
| cmd_pop | input | 1 | Removes the oldest command |
| slot_release | input | 1 | Returns the oldest outstanding slot |
| irq | output | 1 | One-cycle pulse per queued command |

## Verification
The bench runs all four switch combinations, one-byte payloads and long packets. On a missed offset, the payload would land over header bytes or leave a gap, and the byte comparison would flag it. Payloads of 1600 bytes check the clipping point. A design that kept writing would report a size above MAX_FRAME and overwrite bytes past it, which the bench sees through sentinel bytes. The bench fills every slot and queue entry while the consumer holds back. A design that miscounted free slots would raise `in_ready`, or would stay stalled after a release. A pop on an empty queue and the streamed-frame counter wrapping past 16 frames are both checked, since either would show up as a wrong pointer or a wrong prefix nibble on the following frame.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;

    typedef struct packed {
        logic [47:0] dmac;
        logic [15:0] etype;
        logic [31:0] dip;
        logic [15:0] dport;
        logic        ip_en;
        logic        strm_en;
    } port_ent_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PAY  = 2'd1,
        ST_HDR  = 2'd2
    } phase_e;

    typedef struct packed {
        port_ent_t   ent;
        logic [47:0] smac;
        logic [31:0] sip;
        logic [15:0] sport;
        logic [15:0] totlen;
        logic [15:0] udplen;
        logic [15:0] paylen;
        logic [15:0] csum;
        logic [3:0]  seq;
        logic [7:0]  port;
    } hdr_fields_t;

    // End-around-carry sum of the fixed IPv4 words plus the variable ones, inverted.
    function automatic logic [15:0] ip_csum(input logic [15:0] totlen,
                                            input logic [31:0] sip,
                                            input logic [31:0] dip);
        logic [19:0] s;
        s = 20'h04500 + 20'(totlen) + 20'h04000 + 20'h04011
          + 20'(sip[31:16]) + 20'(sip[15:0]) + 20'(dip[31:16]) + 20'(dip[15:0]);
        s = 20'(s[15:0]) + 20'(s[19:16]);
        s = 20'(s[15:0]) + 20'(s[19:16]);
        return ~s[15:0];
    endfunction

    // Byte idx of the header built from f; layout depends on the two switches.
    function automatic logic [7:0] hdr_byte(input logic [5:0] idx, input hdr_fields_t f);
        logic [111:0] eth;
        logic [223:0] ipu;
        logic [31:0]  pre;
        logic [5:0]   r;
        eth = {f.ent.dmac, f.smac, f.ent.etype};
        ipu = {16'h4500, f.totlen, 16'h0000, 16'h4000, 8'h40, 8'h11, f.csum,
               f.sip, f.ent.dip, f.sport, f.ent.dport, f.udplen, 16'h0000};
        pre = {4'h1, f.seq, f.port, f.paylen};
        if (idx < 6'd14) begin
            eth = eth << (8 * idx);
            return eth[111:104];
        end
        r = idx - 6'd14;
        if (f.ent.ip_en) begin
            if (r < 6'd28) begin
                ipu = ipu << (8 * r);
                return ipu[223:216];
            end
            r = r - 6'd28;
        end
        pre = pre << (8 * r);
        return pre[31:24];
    endfunction

endpackage

// File: rtl/ethtx_port_table.sv
module ethtx_port_table
    import ethtx_pkg::*;
#(
    parameter int PORTS = 8,
    localparam int PW = $clog2(PORTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  port_ent_t     wr_ent,
    input  logic [PW-1:0] rd_idx,
    output port_ent_t     rd_ent
);

    port_ent_t ent_q [PORTS];

    // One register per port; a write touches only its own entry (R12).
    for (genvar g = 0; g < PORTS; g++) begin : g_ent
        port_ent_t ent_d;
        always_comb begin
            ent_d = ent_q[g];
            if (wr_en && (wr_idx == PW'(g))) ent_d = wr_ent;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) ent_q[g] <= '0;
            else        ent_q[g] <= ent_d;
        end
    end

    assign rd_ent = ent_q[rd_idx];

endmodule

// File: rtl/ethtx_slot_ctrl.sv
module ethtx_slot_ctrl #(
    parameter int NUM_SLOTS = 4,
    parameter int CMD_DEPTH = 4,
    localparam int SIW = $clog2(NUM_SLOTS),
    localparam int FRW = $clog2(NUM_SLOTS + 1),
    localparam int FW  = $clog2(CMD_DEPTH),
    localparam int CW  = $clog2(CMD_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_i,
    input  logic           release_i,
    input  logic           push_i,
    input  logic [31:0]    push_word_i,
    input  logic           pop_i,
    output logic           avail_o,
    output logic [SIW-1:0] slot_o,
    output logic           cmd_valid_o,
    output logic [31:0]    cmd_word_o
);

    localparam logic [FRW-1:0] FREE_MAX  = FRW'(NUM_SLOTS);
    localparam logic [SIW-1:0] SLOT_LAST = SIW'(NUM_SLOTS - 1);
    localparam logic [FW-1:0]  PTR_LAST  = FW'(CMD_DEPTH - 1);
    localparam logic [CW-1:0]  CNT_MAX   = CW'(CMD_DEPTH);

    typedef struct packed {
        logic [FRW-1:0]                free;
        logic [SIW-1:0]                nxt;
        logic [FW-1:0]                 wp;
        logic [FW-1:0]                 rp;
        logic [CW-1:0]                 cnt;
        logic [CMD_DEPTH-1:0][31:0]    mem;
    } sc_t;

    sc_t q, d;
    logic do_pop;

    always_comb begin
        d      = q;
        do_pop = pop_i && (q.cnt != '0);   // empty pop ignored (R11)

        // slot accounting: taken at packet start, returned in issue order (R9)
        if (alloc_i && !release_i) d.free = q.free - 1'b1;
        else if (release_i && !alloc_i && (q.free != FREE_MAX)) d.free = q.free + 1'b1;
        if (alloc_i) d.nxt = (q.nxt == SLOT_LAST) ? '0 : q.nxt + 1'b1;

        if (push_i) begin
            d.mem[q.wp] = push_word_i;
            d.wp = (q.wp == PTR_LAST) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) d.rp = (q.rp == PTR_LAST) ? '0 : q.rp + 1'b1;
        if (push_i && !do_pop)      d.cnt = q.cnt + 1'b1;
        else if (do_pop && !push_i) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.free <= FREE_MAX;
        end else begin
            q <= d;
        end
    end

    assign avail_o     = (q.free != '0) && (q.cnt != CNT_MAX);
    assign slot_o      = q.nxt;
    assign cmd_valid_o = (q.cnt != '0);
    assign cmd_word_o  = q.mem[q.rp];

endmodule

// File: rtl/ethtx_hdrgen.sv
module ethtx_hdrgen
    import ethtx_pkg::*;
#(
    parameter int PORTS      = 8,
    parameter int NUM_SLOTS  = 4,
    parameter int CMD_DEPTH  = 4,
    parameter int SLOT_BYTES = 2048,
    parameter int MAX_FRAME  = 1514,
    localparam int PW  = $clog2(PORTS),
    localparam int SIW = $clog2(NUM_SLOTS),
    localparam int SBW = $clog2(SLOT_BYTES),
    localparam int AW  = SIW + SBW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [47:0]   cfg_src_mac,
    input  logic [31:0]   cfg_src_ip,
    input  logic [15:0]   cfg_src_udp,
    input  logic          tbl_we,
    input  logic [PW-1:0] tbl_idx,
    input  logic [47:0]   tbl_dmac,
    input  logic [15:0]   tbl_etype,
    input  logic [31:0]   tbl_dip,
    input  logic [15:0]   tbl_dport,
    input  logic          tbl_ip_en,
    input  logic          tbl_strm_en,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic [PW-1:0] in_port,
    input  logic          in_last,
    output logic          buf_we,
    output logic [AW-1:0] buf_addr,
    output logic [7:0]    buf_wdata,
    output logic          cmd_valid,
    output logic [31:0]   cmd_word,
    input  logic          cmd_pop,
    input  logic          slot_release,
    output logic          irq
);

    localparam logic [13:0] MAXF = 14'(MAX_FRAME);

    typedef struct packed {
        phase_e         ph;
        port_ent_t      ent;
        logic [7:0]     port;
        logic [SIW-1:0] slot;
        logic [5:0]     hlen;
        logic [13:0]    pcnt;
        logic [5:0]     hidx;
        logic [3:0]     seq;
        logic           we;
        logic [AW-1:0]  addr;
        logic [7:0]     data;
        logic           irq;
    } st_t;

    st_t q, d;

    port_ent_t      wr_ent, rd_ent;
    logic           avail, alloc, push;
    logic [SIW-1:0] free_slot;
    logic [31:0]    push_word;
    logic           rdy_c;
    hdr_fields_t    f;
    logic [13:0]    pos;
    logic [5:0]     new_hlen;
    logic [15:0]    pre_len;
    logic [AW-1:0]  base;

    assign wr_ent = '{dmac: tbl_dmac, etype: tbl_etype, dip: tbl_dip,
                      dport: tbl_dport, ip_en: tbl_ip_en, strm_en: tbl_strm_en};

    ethtx_port_table #(.PORTS(PORTS)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_idx (tbl_idx),
        .wr_ent (wr_ent),
        .rd_idx (in_port),
        .rd_ent (rd_ent)
    );

    ethtx_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .CMD_DEPTH(CMD_DEPTH)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (alloc),
        .release_i   (slot_release),
        .push_i      (push),
        .push_word_i (push_word),
        .pop_i       (cmd_pop),
        .avail_o     (avail),
        .slot_o      (free_slot),
        .cmd_valid_o (cmd_valid),
        .cmd_word_o  (cmd_word)
    );

    // Header fields from the latched entry and the kept payload count (R3, R10)
    always_comb begin
        pre_len  = q.ent.strm_en ? 16'd4 : 16'd0;
        f.ent    = q.ent;
        f.smac   = cfg_src_mac;
        f.sip    = cfg_src_ip;
        f.sport  = cfg_src_udp;
        f.totlen = 16'd28 + pre_len + 16'(q.pcnt);
        f.udplen = 16'd8 + pre_len + 16'(q.pcnt);
        f.paylen = 16'(q.pcnt);
        f.csum   = ip_csum(f.totlen, cfg_src_ip, q.ent.dip);
        f.seq    = q.seq;
        f.port   = q.port;
    end

    assign new_hlen  = 6'd14 + (rd_ent.ip_en ? 6'd28 : 6'd0) + (rd_ent.strm_en ? 6'd4 : 6'd0);
    assign pos       = 14'(q.hlen) + q.pcnt;
    assign base      = {q.slot, {SBW{1'b0}}};
    assign push_word = {2'b00, pos, 16'(base)};   // R7

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.irq  = 1'b0;
        alloc  = 1'b0;
        push   = 1'b0;
        rdy_c  = 1'b0;
        unique case (q.ph)
            ST_IDLE: begin
                rdy_c = avail;                          // R9
                if (in_valid && avail) begin
                    alloc  = 1'b1;
                    d.ent  = rd_ent;
                    d.port = 8'(in_port);
                    d.slot = free_slot;
                    d.hlen = new_hlen;
                    d.we   = 1'b1;
                    d.addr = {free_slot, SBW'(new_hlen)};
                    d.data = in_data;
                    d.pcnt = 14'd1;
                    d.hidx = '0;
                    d.ph   = in_last ? ST_HDR : ST_PAY;
                end
            end
            ST_PAY: begin
                rdy_c = 1'b1;
                if (in_valid) begin
                    if (pos < MAXF) begin               // R10
                        d.we   = 1'b1;
                        d.addr = {q.slot, SBW'(pos)};
                        d.data = in_data;
                        d.pcnt = q.pcnt + 14'd1;
                    end
                    if (in_last) d.ph = ST_HDR;
                end
            end
            ST_HDR: begin
                d.we   = 1'b1;
                d.addr = {q.slot, SBW'(q.hidx)};
                d.data = hdr_byte(q.hidx, f);
                d.hidx = q.hidx + 6'd1;
                if (q.hidx == (q.hlen - 6'd1)) begin
                    push  = 1'b1;
                    d.irq = 1'b1;                       // R8
                    d.ph  = ST_IDLE;
                    if (q.ent.strm_en) d.seq = q.seq + 4'd1;   // R5
                end
            end
            default: d.ph = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready  = rdy_c;
    assign buf_we    = q.we;
    assign buf_addr  = q.addr;
    assign buf_wdata = q.data;
    assign irq       = q.irq;

endmodule

// File: rtl/ethtx_hdrgen_chk.sv
module ethtx_hdrgen_chk #(
    parameter int NUM_SLOTS  = 4,
    parameter int SLOT_BYTES = 2048,
    parameter int MAX_FRAME  = 1514,
    parameter int AW         = 13,
    localparam int SBW = $clog2(SLOT_BYTES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          cmd_valid,
    input logic [31:0]   cmd_word,
    input logic          buf_we,
    input logic [AW-1:0] buf_addr,
    input logic          slot_release,
    input logic          in_ready
);

    int outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= 0;
        else if (irq && !slot_release) outstanding <= outstanding + 1;
        else if (slot_release && !irq && outstanding > 0) outstanding <= outstanding - 1;
    end

    AST_IRQ_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cmd_valid);                                                  // R8
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                       // R8
    AST_CMD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_word[31:30] == 2'b00));                           // R7
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_word[SBW-1:0] == '0));                            // R7
    AST_SIZE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (int'(cmd_word[29:16]) <= MAX_FRAME && int'(cmd_word[29:16]) >= 15)); // R10
    AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (int'(buf_addr[SBW-1:0]) < MAX_FRAME));                   // R10
    AST_NO_OVERCOMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= NUM_SLOTS);                                           // R9
    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding == NUM_SLOTS) |-> !in_ready);                           // R9

endmodule

bind ethtx_hdrgen ethtx_hdrgen_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .SLOT_BYTES (SLOT_BYTES),
    .MAX_FRAME  (MAX_FRAME),
    .AW         (AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .slot_release (slot_release),
    .in_ready     (in_ready)
);

// File: tb/tb_ethtx_hdrgen.sv
module tb_ethtx_hdrgen;

    localparam int PORTS = 8;
    localparam int NS    = 4;
    localparam int SB    = 2048;
    localparam int MF    = 1514;
    localparam int PW    = 3;
    localparam int AW    = 13;
    localparam logic [47:0] SMAC  = 48'h02_11_22_33_44_55;
    localparam logic [31:0] SIP   = 32'hC0A8_0A01;
    localparam logic [15:0] SPORT = 16'd5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_we = 1'b0;
    logic [PW-1:0] tbl_idx = '0;
    logic [47:0] tbl_dmac = '0;
    logic [15:0] tbl_etype = '0;
    logic [31:0] tbl_dip = '0;
    logic [15:0] tbl_dport = '0;
    logic tbl_ip_en = 1'b0, tbl_strm_en = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic [PW-1:0] in_port = '0;
    logic cmd_pop = 1'b0, slot_release = 1'b0;
    logic in_ready, buf_we, cmd_valid, irq;
    logic [AW-1:0] buf_addr;
    logic [7:0] buf_wdata;
    logic [31:0] cmd_word;

    always #10 clk = ~clk;

    ethtx_hdrgen dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_src_mac(SMAC), .cfg_src_ip(SIP), .cfg_src_udp(SPORT),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_dmac(tbl_dmac), .tbl_etype(tbl_etype),
        .tbl_dip(tbl_dip), .tbl_dport(tbl_dport), .tbl_ip_en(tbl_ip_en), .tbl_strm_en(tbl_strm_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_port(in_port),
        .in_last(in_last), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_pop(cmd_pop),
        .slot_release(slot_release), .irq(irq)
    );

    logic [7:0] mem [NS*SB];
    always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

    int irq_cnt = 0;
    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    logic [47:0] m_dmac [PORTS];
    logic [15:0] m_et [PORTS];
    logic [31:0] m_dip [PORTS];
    logic [15:0] m_dport [PORTS];
    bit m_ip [PORTS];
    bit m_st [PORTS];

    logic [7:0] exp_fr [NS][$];
    bit exp_ip [NS];
    bit exp_st [NS];
    int snd_slot = 0, pop_slot = 0, seq_m = 0, popped = 0;
    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    function automatic string tag_of(int idx, bit ip, bit st);
        int b;
        if (idx < 14) return "R1 eth header";
        if (ip) begin
            if (idx == 16 || idx == 17 || idx == 24 || idx == 25 || idx == 38 || idx == 39)
                return "R3 length/checksum";
            if (idx < 42) return "R2 ip/udp header";
        end
        b = ip ? 42 : 14;
        if (st && idx < b + 4) return "R5 stream prefix";
        return "R4 payload placement";
    endfunction

    task automatic set_port(int p, logic [47:0] dm, logic [15:0] et, logic [31:0] dip,
                            logic [15:0] dp, bit ip, bit st);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = PW'(p); tbl_dmac = dm; tbl_etype = et;
        tbl_dip = dip; tbl_dport = dp; tbl_ip_en = ip; tbl_strm_en = st;
        @(negedge clk);
        tbl_we = 1'b0;
        m_dmac[p] = dm; m_et[p] = et; m_dip[p] = dip; m_dport[p] = dp; m_ip[p] = ip; m_st[p] = st;
    endtask

    task automatic rand_port(int p);
        set_port(p, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, 16'($urandom), $urandom,
                 16'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    endtask

    task automatic send(int p, int len, int gap);
        logic [7:0] pay [$];
        logic [7:0] q [$];
        int hl, kept, pre, tl, ul, i;
        longint s;
        for (int k = 0; k < len; k++) pay.push_back(8'($urandom));
        pre  = m_st[p] ? 4 : 0;
        hl   = 14 + (m_ip[p] ? 28 : 0) + pre;
        kept = (len < MF - hl) ? len : MF - hl;
        for (int k = 5; k >= 0; k--) q.push_back(m_dmac[p][8*k +: 8]);
        for (int k = 5; k >= 0; k--) q.push_back(SMAC[8*k +: 8]);
        q.push_back(m_et[p][15:8]); q.push_back(m_et[p][7:0]);
        if (m_ip[p]) begin
            tl = 28 + pre + kept; ul = 8 + pre + kept;
            q.push_back(8'h45); q.push_back(8'h00); q.push_back(8'(tl >> 8)); q.push_back(8'(tl));
            q.push_back(8'h00); q.push_back(8'h00); q.push_back(8'h40); q.push_back(8'h00);
            q.push_back(8'h40); q.push_back(8'h11); q.push_back(8'h00); q.push_back(8'h00);
            for (int k = 3; k >= 0; k--) q.push_back(SIP[8*k +: 8]);
            for (int k = 3; k >= 0; k--) q.push_back(m_dip[p][8*k +: 8]);
            s = 0;
            for (int k = 0; k < 10; k++) s += {q[14 + 2*k], q[15 + 2*k]};
            while (s > 64'hFFFF) s = (s & 64'hFFFF) + (s >> 16);
            s = ~s & 64'hFFFF;
            q[24] = 8'(s >> 8); q[25] = 8'(s);
            q.push_back(SPORT[15:8]); q.push_back(SPORT[7:0]);
            q.push_back(m_dport[p][15:8]); q.push_back(m_dport[p][7:0]);
            q.push_back(8'(ul >> 8)); q.push_back(8'(ul)); q.push_back(8'h00); q.push_back(8'h00);
        end
        if (m_st[p]) begin
            q.push_back({4'h1, 4'(seq_m)}); q.push_back(8'(p));
            q.push_back(8'(kept >> 8)); q.push_back(8'(kept));
            seq_m++;
        end
        for (int k = 0; k < kept; k++) q.push_back(pay[k]);
        exp_fr[snd_slot] = q; exp_ip[snd_slot] = m_ip[p]; exp_st[snd_slot] = m_st[p];
        snd_slot = (snd_slot + 1) % NS;
        i = 0;
        while (i < len) begin
            @(negedge clk);
            in_valid = ($urandom_range(0, 99) >= gap);
            in_data = pay[i]; in_port = PW'(p); in_last = (i == len - 1);
            if (in_valid && in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic expect_frame();
        int t, ptr, sz, bad, bidx;
        t = 0;
        while (!cmd_valid && t < 5000) begin @(negedge clk); t++; end
        chk(cmd_valid, "R8 command queued", longint'(cmd_valid), 1);
        @(negedge clk);
        ptr = int'(cmd_word[15:0]); sz = int'(cmd_word[29:16]);
        chk(irq_cnt >= popped + 1, "R8 irq per command", irq_cnt, popped + 1);
        chk(cmd_word[31:30] == 2'b00 && ptr == pop_slot * SB, "R7 pointer / R11 order",
            cmd_word, pop_slot * SB);
        chk(sz == exp_fr[pop_slot].size(), "R6 frame size", sz, exp_fr[pop_slot].size());
        bad = 0; bidx = 0;
        for (int k = 0; k < exp_fr[pop_slot].size(); k++)
            if (bad == 0 && mem[pop_slot*SB + k] !== exp_fr[pop_slot][k]) begin bad = 1; bidx = k; end
        chk(bad == 0, bad ? tag_of(bidx, exp_ip[pop_slot], exp_st[pop_slot]) : "R1 frame bytes",
            mem[pop_slot*SB + bidx], exp_fr[pop_slot][bidx]);
        chk(mem[pop_slot*SB + exp_fr[pop_slot].size()] == 8'hEE, "R6 no byte past frame",
            mem[pop_slot*SB + exp_fr[pop_slot].size()], 8'hEE);
        for (int k = 0; k < SB; k++) mem[pop_slot*SB + k] = 8'hEE;
        cmd_pop = 1'b1;
        @(negedge clk);
        cmd_pop = 1'b0;
        pop_slot = (pop_slot + 1) % NS;
        popped++;
    endtask

    task automatic release_one();
        @(negedge clk); slot_release = 1'b1;
        @(negedge clk); slot_release = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired act=1 exp=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < NS*SB; k++) mem[k] = 8'hEE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
        chk(cmd_valid == 1'b0 && irq == 1'b0 && buf_we == 1'b0, "R11 idle after reset",
            {cmd_valid, irq, buf_we}, 0);

        set_port(0, 48'hA1A2A3A4A5A6, 16'h88B5, 32'h0A000001, 16'd1000, 0, 0);
        set_port(1, 48'hB1B2B3B4B5B6, 16'h0800, 32'h0A000002, 16'd1001, 1, 0);
        set_port(2, 48'hC1C2C3C4C5C6, 16'h88B6, 32'h0A000003, 16'd1002, 0, 1);
        set_port(3, 48'hD1D2D3D4D5D6, 16'h0800, 32'h0A000004, 16'd1003, 1, 1);
        for (int p = 4; p < PORTS; p++) rand_port(p);

        // directed: every switch combination, short and medium payloads
        for (int p = 0; p < 4; p++) begin
            send(p, 1, 0);  expect_frame(); release_one();
            send(p, 64, 30); expect_frame(); release_one();
        end

        // R11: pop with empty queue has no effect
        @(negedge clk); cmd_pop = 1'b1; @(negedge clk); cmd_pop = 1'b0;
        chk(cmd_valid == 1'b0, "R11 empty pop ignored", cmd_valid, 0);
        send(3, 10, 0); expect_frame(); release_one();

        // R10: oversize payloads clipped at MAX_FRAME
        send(3, 1600, 0); expect_frame(); release_one();
        chk(exp_fr[(pop_slot + NS - 1) % NS].size() == MF, "R10 clipped size", exp_fr[(pop_slot + NS - 1) % NS].size(), MF);
        send(0, 1600, 10); expect_frame(); release_one();

        // R9: fill every slot with the consumer stalled
        for (int k = 0; k < NS; k++) send(k % 4, 20 + k, 20);
        repeat (60) @(negedge clk);
        chk(in_ready == 1'b0, "R9 stalled with all slots full", in_ready, 0);
        for (int k = 0; k < NS; k++) expect_frame();
        @(negedge clk);
        chk(in_ready == 1'b0, "R9 stalled until slot returned", in_ready, 0);
        release_one();
        chk(in_ready == 1'b1, "R9 ready after release", in_ready, 1);
        for (int k = 1; k < NS; k++) release_one();

        // R12: rewrite one port, neighbour unchanged
        set_port(1, 48'hE1E2E3E4E5E6, 16'h0801, 32'h0B0B0B0B, 16'd2222, 1, 1);
        send(1, 33, 0); expect_frame(); release_one();
        send(0, 33, 0); expect_frame(); release_one();
        chk(m_ip[0] == 0 && m_st[0] == 0, "R12 neighbour entry kept", m_ip[0], 0);

        // random traffic; also carries the stream counter past 16
        for (int n = 0; n < 30; n++) begin
            if ($urandom_range(0, 4) == 0) rand_port($urandom_range(0, PORTS - 1));
            send($urandom_range(0, PORTS - 1), $urandom_range(1, 300), $urandom_range(0, 50));
            expect_frame();
            release_one();
        end
        chk(irq_cnt == popped, "R8 irq count matches commands", irq_cnt, popped);

        finish_run();
    end

endmodule